// File: doc/BRIEF.md
# Three-Operand Adder Procedure Register Block

This block is a bus slave that turns two word registers into a hardware procedure call. Software stages three operands in the registers and then starts the procedure. The operands are A (20 bits), B (10 bits) and C (8 bits). C is split between the two registers. The procedure adds the three operands. The 21-bit result is placed in the second register, next to the upper part of C. Software reads the result back from there.

The block marks the procedure boundaries with two pulses. A write to the second register is the last parameter write, so it starts the call: a one-clock `call_o` pulse follows, and on that pulse the result register loads the new sum. A read of the second register is the last return read, so it ends the call: a one-clock `exit_o` pulse follows. A write to the first register only stages values. A read of the first register returns the staged values and raises no pulse.

The port is single-cycle. An access is taken in any cycle where `cyc_i` and `stb_i` are both high. `ack_o` and the read data come back combinationally in that same cycle. The register is selected by a one-bit word address.

Top module: `proccall_regblock`

## Requirements
- R1: Synchronous active-high reset clears all staged operands, the result and both pulses. After reset, both registers read as zero and `call_o` and `exit_o` are low.
- R2: Register 0 (address 0) holds A in bits 31:12, B in bits 11:2 and C[1:0] in bits 1:0. A write replaces all three fields. A read returns them in the same layout.
- R3: Register 1 (address 1) holds C[7:2] in bits 5:0. A write to it changes only C[7:2], and its other written bits are ignored. On read, bits 31:27 are zero.
- R4: A write to register 1 raises `call_o` for exactly the next clock. A write to register 0 never raises `call_o`.
- R5: On each clock edge where `call_o` is high, the result loads A+B+C, using the operand values held before that edge. Between calls the result holds. The result is read in bits 26:6 of register 1.
- R6: A read of register 1 raises `exit_o` for exactly the next clock. A read of register 0 never raises `exit_o`.
- R7: `ack_o` equals `cyc_i && stb_i` in the same cycle. No access takes place when `cyc_i` or `stb_i` is low. `dat_o` is zero in any cycle without a read.
- R8: A write to register 0 in the cycle where `call_o` is high stages new operands but does not change the result of the call in progress.
- R9: Writes to register 1 in consecutive cycles give one `call_o` pulse per write. The result ends at the sum of the operands staged by the last write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_i | input | 1 | Bus cycle valid |
| stb_i | input | 1 | Access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | 1 | Word address: 0 = operand register, 1 = operand/result register |
| dat_i | input | 32 | Write data |
| ack_o | output | 1 | Same-cycle acknowledge |
| dat_o | output | 32 | Read data, zero when not reading |
| call_o | output | 1 | One-clock pulse after a write of register 1 |
| exit_o | output | 1 | One-clock pulse after a read of register 1 |

## Verification
The risky collision is a result update and an access in the same cycle, which happens in the clock right after a write to register 1. The bench provokes it in two ways. In one case it reads register 1 during the `call_o` cycle; that read must return the previous result and must still raise `exit_o`. In the other case it writes register 0 during the `call_o` cycle; the result must then come from the operands that were staged before that write. A behavioural reference model, updated at every clock edge, judges the read data, the acknowledge and both pulses on every clock. Directed reads of register 1 then compare the result against sums computed by the bench.

// File: rtl/proccall_pkg.sv
package proccall_pkg;

    localparam int DATA_W  = 32;
    localparam int A_W     = 20;
    localparam int B_W     = 10;
    localparam int C_W     = 8;
    localparam int C_LO_W  = DATA_W - A_W - B_W;
    localparam int C_HI_W  = C_W - C_LO_W;
    localparam int SUM_W   = A_W + 1;
    localparam int RET_LSB = C_HI_W;
    localparam int PAD_LSB = C_HI_W + SUM_W;

    typedef enum logic [0:0] {
        REG_ARGS = 1'b0,
        REG_RET  = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
        logic [C_W-1:0] c;
    } proc_args_t;

    typedef struct packed {
        logic              valid;
        logic              we;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic [DATA_W-1:0] pack_args(input proc_args_t p);
        return {p.a, p.b, p.c[C_LO_W-1:0]};
    endfunction

    function automatic logic [DATA_W-1:0] pack_ret(input logic [SUM_W-1:0] s,
                                                   input logic [C_W-1:0]   c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[C_HI_W-1:0]     = c[C_W-1:C_LO_W];
        w[RET_LSB +: SUM_W] = s;
        return w;
    endfunction

    function automatic logic [SUM_W-1:0] add3(input proc_args_t p);
        return SUM_W'(p.a) + SUM_W'(p.b) + SUM_W'(p.c);
    endfunction

endpackage

// File: rtl/pc_bus_decode.sv
module pc_bus_decode
    import proccall_pkg::*;
(
    input  logic              cyc_i,
    input  logic              stb_i,
    input  logic              we_i,
    input  logic              adr_i,
    input  logic [DATA_W-1:0] dat_i,
    output bus_req_t          req_o,
    output logic              ack_o
);

    always_comb begin
        req_o.valid = cyc_i && stb_i;
        req_o.we    = we_i;
        req_o.sel   = reg_sel_e'(adr_i);
        req_o.wdata = dat_i;
    end

    assign ack_o = req_o.valid;

endmodule

// File: rtl/pc_arg_stage.sv
module pc_arg_stage
    import proccall_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_req_t   req_i,
    output proc_args_t args_o,
    output logic       call_o
);

    proc_args_t args_q;
    logic       call_q;
    logic       wr_args;
    logic       wr_ret;

    assign wr_args = req_i.valid && req_i.we && (req_i.sel == REG_ARGS);
    assign wr_ret  = req_i.valid && req_i.we && (req_i.sel == REG_RET);

    always_ff @(posedge clk) begin
        if (rst) begin
            args_q <= '0;
            call_q <= 1'b0;
        end else begin
            call_q <= wr_ret;
            if (wr_args) begin
                args_q.a              <= req_i.wdata[C_LO_W+B_W +: A_W];
                args_q.b              <= req_i.wdata[C_LO_W +: B_W];
                args_q.c[C_LO_W-1:0]  <= req_i.wdata[C_LO_W-1:0];
            end
            if (wr_ret) begin
                args_q.c[C_W-1:C_LO_W] <= req_i.wdata[C_HI_W-1:0];
            end
        end
    end

    assign args_o = args_q;
    assign call_o = call_q;

    AST_CALL_ON_RET_WRITE: assert property (@(posedge clk) disable iff (rst)
        (req_i.valid && req_i.we && req_i.sel == REG_RET) |=> call_o); // R4
    AST_NO_CALL_OTHERWISE: assert property (@(posedge clk) disable iff (rst)
        !(req_i.valid && req_i.we && req_i.sel == REG_RET) |=> !call_o); // R4
    AST_RET_WRITE_KEEPS_A: assert property (@(posedge clk) disable iff (rst)
        (req_i.valid && req_i.we && req_i.sel == REG_RET) |=> $stable(args_o.a)); // R3

endmodule

// File: rtl/pc_sum_core.sv
module pc_sum_core
    import proccall_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             call_i,
    input  proc_args_t       args_i,
    output logic [SUM_W-1:0] sum_o
);

    logic [SUM_W-1:0] sum_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
        end else if (call_i) begin
            sum_q <= add3(args_i);
        end
    end

    assign sum_o = sum_q;

    AST_SUM_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !call_i |=> $stable(sum_o)); // R5
    AST_SUM_FROM_OLD_ARGS: assert property (@(posedge clk) disable iff (rst)
        call_i |=> (sum_o == SUM_W'($past(args_i.a)) + SUM_W'($past(args_i.b))
                             + SUM_W'($past(args_i.c)))); // R8

endmodule

// File: rtl/pc_read_port.sv
module pc_read_port
    import proccall_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_valid_i,
    input  logic              rd_we_i,
    input  reg_sel_e          rd_sel_i,
    input  proc_args_t        args_i,
    input  logic [SUM_W-1:0]  sum_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              exit_o
);

    logic rd_hit;
    logic exit_q;

    assign rd_hit = rd_valid_i && !rd_we_i;

    always_comb begin
        rdata_o = '0;
        if (rd_hit) begin
            unique case (rd_sel_i)
                REG_ARGS: rdata_o = pack_args(args_i);
                REG_RET:  rdata_o = pack_ret(sum_i, args_i.c);
                default:  rdata_o = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            exit_q <= 1'b0;
        end else begin
            exit_q <= rd_hit && (rd_sel_i == REG_RET);
        end
    end

    assign exit_o = exit_q;

    AST_EXIT_ON_RET_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && rd_sel_i == REG_RET) |=> exit_o); // R6
    AST_NO_EXIT_OTHERWISE: assert property (@(posedge clk) disable iff (rst)
        !(rd_hit && rd_sel_i == REG_RET) |=> !exit_o); // R6
    AST_RET_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && rd_sel_i == REG_RET) |-> (rdata_o[DATA_W-1:PAD_LSB] == '0)); // R3
    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_hit |-> (rdata_o == '0)); // R7

endmodule

// File: rtl/proccall_regblock.sv
module proccall_regblock
    import proccall_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_i,
    input  logic              stb_i,
    input  logic              we_i,
    input  logic              adr_i,
    input  logic [DATA_W-1:0] dat_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] dat_o,
    output logic              call_o,
    output logic              exit_o
);

    bus_req_t         req;
    proc_args_t       args;
    logic [SUM_W-1:0] sum;

    pc_bus_decode u_decode (
        .cyc_i (cyc_i),
        .stb_i (stb_i),
        .we_i  (we_i),
        .adr_i (adr_i),
        .dat_i (dat_i),
        .req_o (req),
        .ack_o (ack_o)
    );

    pc_arg_stage u_args (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req),
        .args_o (args),
        .call_o (call_o)
    );

    pc_sum_core u_sum (
        .clk    (clk),
        .rst    (rst),
        .call_i (call_o),
        .args_i (args),
        .sum_o  (sum)
    );

    pc_read_port u_read (
        .clk        (clk),
        .rst        (rst),
        .rd_valid_i (req.valid),
        .rd_we_i    (req.we),
        .rd_sel_i   (req.sel),
        .args_i     (args),
        .sum_i      (sum),
        .rdata_o    (dat_o),
        .exit_o     (exit_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!call_o && !exit_o && sum == '0 && args == '0)); // R1

endmodule

// File: tb/sim_proccall_regblock.sv
module sim_proccall_regblock;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc = 1'b0;
    logic        stb = 1'b0;
    logic        we  = 1'b0;
    logic        adr = 1'b0;
    logic [31:0] wd  = '0;
    logic        ack;
    logic [31:0] rd;
    logic        call;
    logic        ext;

    int errors = 0;
    int checks = 0;
    int n_ret_writes = 0;
    int n_calls = 0;
    bit started = 0;
    bit done = 0;

    // reference model state
    longint m_a = 0, m_b = 0, m_c = 0, m_sum = 0;
    bit m_call = 0, m_exit = 0;

    always #4 clk = ~clk;

    proccall_regblock u0 (
        .clk(clk), .rst(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we),
        .adr_i(adr), .dat_i(wd), .ack_o(ack), .dat_o(rd),
        .call_o(call), .exit_o(ext)
    );

    function automatic logic [31:0] word0(longint a, longint b, longint c);
        return 32'((a << 12) | (b << 2) | (c & 3));
    endfunction

    function automatic logic [31:0] word1(longint s, longint c);
        return 32'((s << 6) | ((c >> 2) & 63));
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // model update on every edge, using pre-edge state
    always @(posedge clk) begin
        longint ns;
        bit acc;
        started = 1;
        acc = cyc && stb;
        if (rst) begin
            m_a = 0; m_b = 0; m_c = 0; m_sum = 0; m_call = 0; m_exit = 0;
        end else begin
            ns = m_call ? ((m_a + m_b + m_c) & 64'h1FFFFF) : m_sum;
            if (m_call) n_calls++;
            m_call = acc && we && adr;
            m_exit = acc && !we && adr;
            if (acc && we && !adr) begin
                m_a = (wd >> 12) & 20'hFFFFF;
                m_b = (wd >> 2) & 10'h3FF;
                m_c = (m_c & 8'hFC) | (wd & 3);
            end
            if (acc && we && adr) begin
                m_c = (m_c & 3) | ((wd & 63) << 2);
                n_ret_writes++;
            end
            m_sum = ns;
        end
    end

    // compare every clock away from the edge
    always @(negedge clk) begin
        logic [31:0] exp_rd;
        string tag;
        if (started && !done) begin
            exp_rd = '0;
            tag = "R7";
            if (cyc && stb && !we) begin
                exp_rd = adr ? word1(m_sum, m_c) : word0(m_a, m_b, m_c);
                tag = adr ? "R5" : "R2";
            end
            chk("R7 ack", 32'(ack), 32'(cyc && stb));
            chk(tag, rd, exp_rd);
            chk("R4 call", 32'(call), 32'(m_call));
            chk("R6 exit", 32'(ext), 32'(m_exit));
        end
    end

    task automatic drive(bit v, bit w, bit a, logic [31:0] d);
        @(posedge clk);
        #1;
        cyc = v; stb = v; we = w; adr = a; wd = d;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 32'h0);
    endtask

    task automatic read_expect(bit a, logic [31:0] exp, string tag);
        drive(1, 0, a, 32'h0);
        @(negedge clk);
        chk(tag, rd, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1: reset state
        read_expect(0, 32'h0, "R1 reg0 after reset");
        read_expect(1, 32'h0, "R1 reg1 after reset");
        @(negedge clk); chk("R1 exit after reset read", 32'(ext), 32'd1);
        idle(1);
        @(negedge clk); chk("R1 call low", 32'(call), 32'd0);

        // R2/R3/R4/R5: worked example, garbage above bits 5:0 of reg1 ignored
        drive(1, 1, 0, word0(1045694, 484, 117));
        drive(1, 1, 1, 32'hFFFF_FFC0 | 32'd29);
        drive(0, 0, 0, 32'h0);
        @(negedge clk); chk("R4 call after reg1 write", 32'(call), 32'd1);
        idle(1);
        @(negedge clk); chk("R4 call one clock only", 32'(call), 32'd0);
        read_expect(1, word1(1046295, 117), "R5 example sum");
        read_expect(0, word0(1045694, 484, 117), "R2 reg0 readback");
        read_expect(1, word1(1046295, 117), "R3 pad bits zero");
        idle(1);

        // R4: reg0 write alone does not trigger
        drive(1, 1, 0, word0(7, 8, 3));
        idle(2);
        @(negedge clk); chk("R4 no call from reg0", 32'(call), 32'd0);
        read_expect(1, word1(1046295, 119), "R4 sum unchanged");

        // R6: reg0 read gives no exit
        read_expect(0, word0(7, 8, 119), "R2 reg0 new fields");
        idle(1);
        @(negedge clk); chk("R6 no exit from reg0 read", 32'(ext), 32'd0);

        // collision: read reg1 in the call cycle sees the old sum
        drive(1, 1, 1, 32'd1);
        read_expect(1, word1(1046295, 7), "R5 old sum during call");
        idle(1);
        @(negedge clk); chk("R6 exit after collided read", 32'(ext), 32'd1);
        read_expect(1, word1(7 + 8 + 7, 7), "R5 new sum after call");

        // R8: reg0 write during the call cycle does not enter this result
        drive(1, 1, 0, word0(100, 200, 0));
        drive(1, 1, 1, 32'd2);
        drive(1, 1, 0, word0(5000, 5, 1));
        idle(2);
        read_expect(1, word1(100 + 200 + 8, 9), "R8 sum from pre-call operands");

        // R9: back-to-back reg1 writes, max operands
        drive(1, 1, 0, word0(20'hFFFFF, 10'h3FF, 3));
        drive(1, 1, 1, 32'd0);
        drive(1, 1, 1, 32'd63);
        idle(3);
        read_expect(1, word1(1049853, 255), "R9 last write wins, max sum");

        // R7: strobe without cycle does nothing
        cyc = 0; stb = 1; we = 1; adr = 0; wd = 32'h1234_5678;
        @(negedge clk); chk("R7 no ack without cyc", 32'(ack), 32'd0);
        idle(1);
        read_expect(0, word0(20'hFFFFF, 10'h3FF, 255), "R7 no write without cyc");

        // R1: reset mid-run
        idle(1);
        #1 rst = 1;
        idle(2);
        #1 rst = 0;
        read_expect(1, 32'h0, "R1 reg1 cleared");
        idle(2);
        checks++;
        if (n_calls != n_ret_writes) begin
            errors++;
            $display("FAIL R9 call count actual=%0d expected=%0d", n_calls, n_ret_writes);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule